// File: doc/BRIEF.md
# Timing Command Sequencer with Capture Memory

This block plays a host-loaded list of fast timing commands out to a front-end system, one list entry per bunch-crossing clock. A host fills a playback memory through a simple word-wide memory port, sets an end address and a loop option, and pulses start. Each entry either pulses any mix of the five fast command lines (first-level trigger, event-count reset, bunch-count reset, calibrate, front-end reset), or is an identifier word that sets the trigger type attached to later triggers. Every trigger carries a trigger number, a bunch-crossing number and the trigger type. These appear as registered parallel fields. They also go, as a framed serial stream, through a small FIFO, so that a burst of closely spaced triggers is not lost while earlier frames are still being shifted out.

A capture memory of the same depth records each entry as it is driven while capture is enabled. The host can read both memories back once playback has stopped and compare what was sent with what was recorded. Host accesses made during playback are refused and raise a sticky access-error flag.

Top module: `tcs_sequencer`

## Requirements
- R1: While `rst` is high and after it falls, `busy_o`, all five command lines, `id_ser_o`, `acc_err_o`, `sink_full_o` and `mem_rvalid_o` are 0.
- R2: An entry word is {op[7:5], fer[4], cal[3], bcr[2], ecr[1], l1a[0]}. After a start pulse is sampled while idle, entry k drives its command bits on the output lines for exactly one cycle, k+2 clock edges after the start edge. Only entries with op = 0 drive command lines.
- R3: Without loop, playback ends after the entry at `end_addr_i`. `busy_o` falls at the edge that reads that entry, and that entry is the last one driven.
- R4: With `loop_i` = 1, the entry after `end_addr_i` is entry 0, and playback continues until stopped.
- R5: A stop pulse clears `busy_o` at the next edge. An entry already read at that point is still driven.
- R6: An entry with op = 1 sets the trigger type to its bits [4:0] and drives no command line. Entries with op = 2 to 7 drive nothing and change nothing except the bunch count.
- R7: The trigger number attached to a trigger counts the triggers since start or since the last event-count reset. A reset in the same entry as a trigger makes that trigger number 0.
- R8: The bunch number counts the entries played since start or since the last bunch-count reset. A reset in the same entry makes that entry's bunch number 0.
- R9: Each trigger emits a serial frame on `id_ser_o`: a 1 start bit, then {trigger number[7:0], bunch number[7:0], type[4:0]} MSB first, one bit per clock. The line is 0 between frames.
- R10: Up to four triggers on consecutive entries are all delivered as frames, in order.
- R11: While `capture_i` = 1, every played entry is written to the capture memory at successive addresses from 0. While it is 0, nothing is written.
- R12: `sink_full_o` rises once the capture memory holds its full depth of entries. Further entries are not written, and the flag stays set until the next start.
- R13: With `mem_sel_i` = 0 the host port reads and writes the playback memory; with `mem_sel_i` = 1 it reads the capture memory. Read data comes one cycle after `mem_rd_i`, with `mem_rvalid_o`. While busy, reads return 0, writes are ignored, and both set `acc_err_o`.
- R14: A start accepted while idle clears `acc_err_o`, the trigger and bunch counts, the trigger type and the capture pointer and full flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| stop_i | input | 1 | Stop pulse |
| loop_i | input | 1 | Wrap to entry 0 after the end address |
| capture_i | input | 1 | Enable recording into the capture memory |
| end_addr_i | input | ADDR_W | Last entry played |
| mem_wr_i | input | 1 | Host write strobe |
| mem_rd_i | input | 1 | Host read strobe |
| mem_sel_i | input | 1 | 0 playback memory, 1 capture memory |
| mem_addr_i | input | ADDR_W | Host address |
| mem_wdata_i | input | 8 | Host write data |
| mem_rdata_o | output | 8 | Host read data |
| mem_rvalid_o | output | 1 | Read data valid |
| acc_err_o | output | 1 | Sticky refused-access flag |
| busy_o | output | 1 | Playback running |
| sink_full_o | output | 1 | Capture memory full |
| l1a_o | output | 1 | First-level trigger |
| ecr_o | output | 1 | Event-count reset |
| bcr_o | output | 1 | Bunch-count reset |
| cal_o | output | 1 | Calibrate |
| fer_o | output | 1 | Front-end reset |
| trig_num_o | output | EVT_W | Trigger number of the last trigger |
| bunch_num_o | output | BC_W | Bunch number of the last trigger |
| trig_type_o | output | TYPE_W | Trigger type of the last trigger |
| id_ser_o | output | 1 | Serial identifier frames |

## Verification
A wrong playback pointer or end decision shows two cycles later as a wrong pattern on the command lines, or as `busy_o` falling early or late. The cycle-exact model therefore catches it within that window. A corrupted trigger or bunch count shows on the parallel identifier fields at the very next trigger, and about 22 cycles later in the serial frame, so the same fault is reported twice. A capture pointer that runs wrong shows only when the host reads the capture memory back or when the full flag changes, so the bench reads back every recorded entry and fills the memory in loop mode.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int WORD_W = 8;
  localparam logic [2:0] OP_CMD  = 3'd0;
  localparam logic [2:0] OP_TYPE = 3'd1;

  typedef struct packed {
    logic [2:0] op;
    logic       fer;
    logic       cal;
    logic       bcr;
    logic       ecr;
    logic       l1a;
  } seq_word_t;
endpackage

// File: rtl/tcs_seq_core.sv
module tcs_seq_core #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_ok,
  input  logic              stop,
  input  logic              loop_en,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [7:0]        rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] raddr;

  assign raddr = busy ? ptr : host_addr;

  // single read port shared by playback and host, block-RAM friendly
  always_ff @(posedge clk) begin
    if (host_we && !busy) mem[host_addr] <= host_wdata;
    rd_word <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ptr      <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= busy;
      if (busy) begin
        if (ptr == end_addr) begin
          ptr <= '0;
          if (!loop_en) busy <= 1'b0;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
      if (stop) begin
        busy <= 1'b0;
      end else if (start_ok) begin
        busy <= 1'b1;
        ptr  <= '0;
      end
    end
  end
endmodule

// File: rtl/tcs_sink.sv
module tcs_sink #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [7:0]        wr_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_word,
  output logic              full
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]      mem [DEPTH];
  logic [ADDR_W:0] wp;
  logic            do_wr;

  assign full  = wp[ADDR_W];
  assign do_wr = wr_en && !full;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp[ADDR_W-1:0]] <= wr_word;
    rd_word <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) wp <= '0;
    else if (do_wr)   wp <= wp + 1'b1;
  end
endmodule

// File: rtl/tcs_id_ser.sv
module tcs_id_ser #(
  parameter int FRAME_W = 21,
  parameter int FIFO_AW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [FRAME_W-1:0] frame,
  output logic               ser_o
);
  localparam int DEPTH = 1 << FIFO_AW;
  localparam int CNT_W = FIFO_AW + 1;
  localparam int BIT_W = $clog2(FRAME_W + 2);

  logic [FRAME_W-1:0] fifo [DEPTH];
  logic [FIFO_AW-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W:0]   sr;
  logic [BIT_W-1:0]   bits_left;
  logic               do_push, do_pop;

  assign do_push = push && (cnt != CNT_W'(DEPTH));
  assign do_pop  = (bits_left == '0) && (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_push) fifo[wr_ptr] <= frame;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      sr        <= '0;
      bits_left <= '0;
      ser_o     <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (bits_left != '0) begin
        ser_o     <= sr[FRAME_W];
        sr        <= sr << 1;
        bits_left <= bits_left - 1'b1;
      end else begin
        ser_o <= 1'b0;
        if (do_pop) begin
          sr        <= {1'b1, fifo[rd_ptr]};
          bits_left <= BIT_W'(FRAME_W + 1);
        end
      end
    end
  end
endmodule

// File: rtl/tcs_sequencer.sv
module tcs_sequencer
  import tcs_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int EVT_W   = 8,
  parameter int BC_W    = 8,
  parameter int TYPE_W  = 5,
  parameter int FIFO_AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              loop_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic              mem_wr_i,
  input  logic              mem_rd_i,
  input  logic              mem_sel_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [7:0]        mem_wdata_i,
  output logic [7:0]        mem_rdata_o,
  output logic              mem_rvalid_o,
  output logic              acc_err_o,
  output logic              busy_o,
  output logic              sink_full_o,
  output logic              l1a_o,
  output logic              ecr_o,
  output logic              bcr_o,
  output logic              cal_o,
  output logic              fer_o,
  output logic [EVT_W-1:0]  trig_num_o,
  output logic [BC_W-1:0]   bunch_num_o,
  output logic [TYPE_W-1:0] trig_type_o,
  output logic              id_ser_o
);
  localparam int FRAME_W = EVT_W + BC_W + TYPE_W;

  logic              start_ok;
  logic              rd_valid;
  logic [7:0]        rd_word;
  logic [7:0]        sink_word;
  seq_word_t         w;
  logic              is_cmd, is_type, fire;
  logic [EVT_W-1:0]  ev_cnt, ev_base;
  logic [BC_W-1:0]   bc_cnt, bc_base;
  logic [TYPE_W-1:0] type_q;
  logic              rd_sel_q, rd_err_q;

  assign start_ok = start_i && !busy_o;
  assign w        = seq_word_t'(rd_word);

  tcs_seq_core #(.ADDR_W(ADDR_W)) core_i (
    .clk       (clk),
    .rst       (rst),
    .start_ok  (start_ok),
    .stop      (stop_i),
    .loop_en   (loop_i),
    .end_addr  (end_addr_i),
    .host_we   (mem_wr_i && !mem_sel_i),
    .host_addr (mem_addr_i),
    .host_wdata(mem_wdata_i),
    .busy      (busy_o),
    .rd_valid  (rd_valid),
    .rd_word   (rd_word)
  );

  tcs_sink #(.ADDR_W(ADDR_W)) sink_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (start_ok),
    .wr_en  (rd_valid && capture_i),
    .wr_word(rd_word),
    .rd_addr(mem_addr_i),
    .rd_word(sink_word),
    .full   (sink_full_o)
  );

  tcs_id_ser #(.FRAME_W(FRAME_W), .FIFO_AW(FIFO_AW)) ser_i (
    .clk  (clk),
    .rst  (rst),
    .push (fire),
    .frame({ev_base, bc_base, type_q}),
    .ser_o(id_ser_o)
  );

  // decode of the entry read on the previous edge
  always_comb begin
    is_cmd  = rd_valid && (w.op == OP_CMD);
    is_type = rd_valid && (w.op == OP_TYPE);
    fire    = is_cmd && w.l1a;
    ev_base = (is_cmd && w.ecr) ? '0 : ev_cnt;
    bc_base = (is_cmd && w.bcr) ? '0 : bc_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {l1a_o, ecr_o, bcr_o, cal_o, fer_o} <= '0;
      ev_cnt      <= '0;
      bc_cnt      <= '0;
      type_q      <= '0;
      trig_num_o  <= '0;
      bunch_num_o <= '0;
      trig_type_o <= '0;
    end else begin
      l1a_o <= is_cmd && w.l1a;
      ecr_o <= is_cmd && w.ecr;
      bcr_o <= is_cmd && w.bcr;
      cal_o <= is_cmd && w.cal;
      fer_o <= is_cmd && w.fer;
      if (start_ok) begin
        ev_cnt <= '0;
        bc_cnt <= '0;
        type_q <= '0;
      end else if (rd_valid) begin
        bc_cnt <= bc_base + 1'b1;
        ev_cnt <= fire ? ev_base + 1'b1 : ev_base;
        if (is_type) type_q <= rd_word[TYPE_W-1:0];
      end
      if (fire) begin
        trig_num_o  <= ev_base;
        bunch_num_o <= bc_base;
        trig_type_o <= type_q;
      end
    end
  end

  // host port: one-cycle read latency, refused while playing
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rvalid_o <= 1'b0;
      rd_sel_q     <= 1'b0;
      rd_err_q     <= 1'b0;
      acc_err_o    <= 1'b0;
    end else begin
      mem_rvalid_o <= mem_rd_i;
      if (mem_rd_i) begin
        rd_sel_q <= mem_sel_i;
        rd_err_q <= busy_o;
      end
      if (start_ok)                           acc_err_o <= 1'b0;
      else if ((mem_rd_i || mem_wr_i) && busy_o) acc_err_o <= 1'b1;
    end
  end

  assign mem_rdata_o = rd_err_q ? 8'h00 : (rd_sel_q ? sink_word : rd_word);
endmodule

// File: rtl/tcs_sequencer_chk.sv
module tcs_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       stop_i,
  input logic       mem_rd_i,
  input logic       mem_wr_i,
  input logic [7:0] mem_rdata_o,
  input logic       mem_rvalid_o,
  input logic       acc_err_o,
  input logic       busy_o,
  input logic       sink_full_o,
  input logic       l1a_o,
  input logic       ecr_o,
  input logic       bcr_o,
  input logic       cal_o,
  input logic       fer_o
);
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !start_i |=> !busy_o);

  assert_cmd_needs_play_R2: assert property (@(posedge clk) disable iff (rst)
    (l1a_o || ecr_o || bcr_o || cal_o || fer_o) |-> $past(busy_o, 2));

  assert_stop_halts_R5: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !busy_o);

  assert_read_latency_R13: assert property (@(posedge clk) disable iff (rst)
    mem_rd_i |=> mem_rvalid_o);

  assert_read_refused_R13: assert property (@(posedge clk) disable iff (rst)
    mem_rd_i && busy_o |=> acc_err_o && (mem_rdata_o == 8'h00));

  assert_write_refused_R13: assert property (@(posedge clk) disable iff (rst)
    mem_wr_i && busy_o |=> acc_err_o);

  assert_err_sticky_R14: assert property (@(posedge clk) disable iff (rst)
    acc_err_o && !(start_i && !busy_o) |=> acc_err_o);

  assert_full_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    sink_full_o && !(start_i && !busy_o) |=> sink_full_o);
endmodule

bind tcs_sequencer tcs_sequencer_chk chk_i (.*);

// File: tb/tcs_sequencer_tb_top.sv
`timescale 1ns/1ps
module tcs_sequencer_tb_top;
  localparam int AW = 5;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic start_i = 0, stop_i = 0, loop_i = 0, capture_i = 0;
  logic [AW-1:0] end_addr_i = '0;
  logic mem_wr_i = 0, mem_rd_i = 0, mem_sel_i = 0;
  logic [AW-1:0] mem_addr_i = '0;
  logic [7:0] mem_wdata_i = '0;
  logic [7:0] mem_rdata_o;
  logic mem_rvalid_o, acc_err_o, busy_o, sink_full_o;
  logic l1a_o, ecr_o, bcr_o, cal_o, fer_o, id_ser_o;
  logic [7:0] trig_num_o, bunch_num_o;
  logic [4:0] trig_type_o;

  tcs_sequencer #(.ADDR_W(AW)) dut_i (.*);

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int seq_m [DEPTH];
  int sink_m [DEPTH];
  int frames [$];
  bit m_play, rd_v, m_full, m_err;
  int m_ptr, rd_w, ev, bc, ty, wp, m_cal;
  bit e_l1a, e_ecr, e_bcr, e_cal, e_fer, e_rvalid, e_sel;
  int e_tn, e_bn, e_tt, e_rdata;

  always @(posedge clk) begin
    if (rst) begin
      m_play = 0; rd_v = 0; m_full = 0; m_err = 0; m_ptr = 0;
      ev = 0; bc = 0; ty = 0; wp = 0; m_cal = 0;
      {e_l1a, e_ecr, e_bcr, e_cal, e_fer} = '0;
      e_rvalid = 0; e_tn = 0; e_bn = 0; e_tt = 0;
    end else begin
      bit pre;
      pre = m_play;
      e_rvalid = mem_rd_i;
      if (mem_rd_i) begin
        e_sel = mem_sel_i;
        e_rdata = pre ? 0 : (mem_sel_i ? sink_m[mem_addr_i] : seq_m[mem_addr_i]);
        if (pre) m_err = 1;
      end
      if (mem_wr_i) begin
        if (pre) m_err = 1;
        else if (!mem_sel_i) seq_m[mem_addr_i] = mem_wdata_i;
      end
      {e_l1a, e_ecr, e_bcr, e_cal, e_fer} = '0;
      if (rd_v) begin
        int op;
        op = rd_w >> 5;
        if (op == 0) begin
          e_l1a = rd_w[0]; e_ecr = rd_w[1]; e_bcr = rd_w[2];
          e_cal = rd_w[3]; e_fer = rd_w[4];
          if (e_ecr) ev = 0;
          if (e_bcr) bc = 0;
          if (e_l1a) begin
            e_tn = ev; e_bn = bc; e_tt = ty;
            frames.push_back((ev << 13) | (bc << 5) | ty);
            ev = (ev + 1) % 256;
          end
          if (e_cal) m_cal++;
        end else if (op == 1) begin
          ty = rd_w & 31;
        end
        bc = (bc + 1) % 256;
        if (capture_i && !m_full) begin
          sink_m[wp] = rd_w;
          wp++;
          m_full = (wp == DEPTH);
        end
      end
      rd_v = m_play;
      if (m_play) begin
        rd_w = seq_m[m_ptr];
        if (m_ptr == int'(end_addr_i)) begin
          m_ptr = 0;
          if (!loop_i) m_play = 0;
        end else m_ptr++;
      end
      if (stop_i) m_play = 0;
      else if (start_i && !pre) begin
        m_play = 1; m_ptr = 0; ev = 0; bc = 0; ty = 0;
        wp = 0; m_full = 0; m_err = 0;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  bit cmp_en = 0;
  int d_cal = 0;
  always @(negedge clk) begin
    if (cmp_en) begin
      chk({fer_o, cal_o, bcr_o, ecr_o, l1a_o} == {e_fer, e_cal, e_bcr, e_ecr, e_l1a},
          "R2 command lines", {fer_o, cal_o, bcr_o, ecr_o, l1a_o},
          {e_fer, e_cal, e_bcr, e_ecr, e_l1a});
      chk(int'(trig_num_o) == e_tn, "R7 trigger number", trig_num_o, e_tn);
      chk(int'(bunch_num_o) == e_bn, "R8 bunch number", bunch_num_o, e_bn);
      chk(int'(trig_type_o) == e_tt, "R6 trigger type", trig_type_o, e_tt);
      chk(busy_o == m_play, "R3 busy", busy_o, m_play);
      chk(sink_full_o == m_full, "R12 full flag", sink_full_o, m_full);
      chk(acc_err_o == m_err, "R13 access error", acc_err_o, m_err);
      chk(mem_rvalid_o == e_rvalid, "R13 read valid", mem_rvalid_o, e_rvalid);
      if (e_rvalid)
        chk(int'(mem_rdata_o) == e_rdata, e_sel ? "R11 sink readback" : "R13 host read",
            mem_rdata_o, e_rdata);
      if (cal_o) d_cal++;
    end
  end

  // ---------------- serial frame decoder ----------------
  bit s_act = 0;
  int s_n, s_val, n_frames = 0;
  always @(negedge clk) begin
    if (cmp_en) begin
      if (!s_act) begin
        if (id_ser_o) begin s_act = 1; s_n = 0; s_val = 0; end
      end else begin
        s_val = (s_val << 1) | int'(id_ser_o);
        s_n++;
        if (s_n == 21) begin
          s_act = 0;
          n_frames++;
          if (frames.size() == 0) chk(0, "R9 unexpected frame", s_val, -1);
          else begin
            int exp_f;
            exp_f = frames.pop_front();
            chk(s_val == exp_f, "R9 serial frame", s_val, exp_f);
          end
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic host_write(input int a, input int d);
    mem_wr_i = 1; mem_sel_i = 0; mem_addr_i = AW'(a); mem_wdata_i = 8'(d);
    @(negedge clk);
    mem_wr_i = 0;
  endtask

  task automatic host_read(input bit sel, input int a);
    mem_rd_i = 1; mem_sel_i = sel; mem_addr_i = AW'(a);
    @(negedge clk);
    mem_rd_i = 0;
  endtask

  task automatic pulse_start();
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    cmp_en = 1;
    @(negedge clk);
    // R1 reset state
    chk({busy_o, l1a_o, ecr_o, bcr_o, cal_o, fer_o, id_ser_o, acc_err_o, sink_full_o} == '0,
        "R1 reset state", busy_o, 0);

    // Single pass with a trigger burst, capture on (R2 R3 R6 R7 R8 R9 R11)
    host_write(0, 8'h2A);   // type 0x0A
    host_write(1, 8'h01);   // trigger
    host_write(2, 8'h09);   // trigger + calibrate
    host_write(3, 8'h03);   // trigger + event-count reset
    host_write(4, 8'h05);   // trigger + bunch-count reset
    host_write(5, 8'h10);   // front-end reset
    host_write(6, 8'hBF);   // reserved op: no effect
    host_write(7, 8'h35);   // type 0x15
    host_write(8, 8'h08);   // calibrate
    for (int i = 0; i < 9; i++) host_read(0, i);
    end_addr_i = 5'd8; loop_i = 0; capture_i = 1;
    pulse_start();
    wait_idle();
    for (int i = 0; i < 9; i++) host_read(1, i);

    // Loop mode fills the capture memory (R4 R5 R12 R13)
    host_write(0, 8'h02);
    host_write(1, 8'h04);
    host_write(2, 8'h08);
    host_write(3, 8'h10);
    end_addr_i = 5'd3; loop_i = 1; capture_i = 1;
    pulse_start();
    repeat (10) @(negedge clk);
    host_read(1, 0);          // refused while playing
    host_write(1, 8'hFF);     // ignored while playing
    repeat (30) @(negedge clk);
    stop_i = 1; @(negedge clk); stop_i = 0;
    chk(busy_o == 1'b0, "R5 stop clears busy", busy_o, 0);
    repeat (4) @(negedge clk);
    chk(sink_full_o == 1'b1, "R12 capture memory full", sink_full_o, 1);
    chk(d_cal == m_cal && m_cal > 4, "R4 loop replays calibrate", d_cal, m_cal);
    host_read(0, 1);          // still 0x04
    host_read(1, 31);
    host_read(1, 0);

    // Restart with capture off (R11 R14)
    host_write(0, 8'h23);     // type 3
    host_write(1, 8'h01);     // trigger, number restarts at 0
    host_write(2, 8'h00);
    end_addr_i = 5'd2; loop_i = 0; capture_i = 0;
    pulse_start();
    chk(acc_err_o == 1'b0, "R14 start clears access error", acc_err_o, 0);
    wait_idle();
    chk(sink_full_o == 1'b0, "R11 no capture when disabled", sink_full_o, 0);
    chk(trig_num_o == 8'd0, "R14 trigger number restarted", trig_num_o, 0);
    host_read(1, 0);

    repeat (80) @(negedge clk);
    chk(frames.size() == 0 && n_frames == 5, "R10 all frames delivered", n_frames, 5);
    finish_run();
  end
endmodule